// File: doc/BRIEF.md
# One-Time-Programmable Store Programming Port

This block models the path used to program and check the one-time-programmable program store of a small microcontroller. In normal operation the reset pin only resets the device. A fixed 10-bit key sent on that pin unlocks a programming state. The key goes least-significant bit first, and each bit is sampled on a rising edge of the oscillator clock. An unlocked device stays in the programming state until the reset pin goes low.

In the programming state, the 11-bit store address reaches the block as two phases on one byte-wide address port, and an address-select pin tells the phases apart. The low phase carries address bits 7:0. In the high phase only port bits 2:0 are used, as address bits 10:8. Each phase is captured into its own register, so the complete address persists after the port moves on.

A mode pin picks between checking and writing. In verify mode the addressed byte is driven out with its output enable high. In program mode the output is released and a write strobe stores the incoming byte. The store itself is a behavioural array, and every location that has never been written reads as all ones.

Top module: `otp_prog_access`

## Requirements
- R1: While `rst_n` is low, and at the first sample after it is released, `prog_state` and `data_oe` are 0.
- R2: Outside the programming state, `rst_pin` is sampled on each rising edge of `osc_clk` and compared with bit k of the key parameter (default 10'h2B6), k counting from 0. After the edge that samples a matching bit 9, `prog_state` reads 1.
- R3: A sampled bit that differs from the expected key bit resets the match position to bit 0. A key sent with any wrong bit leaves `prog_state` at 0, and a complete correct key sent later still enters the programming state.
- R4: In the programming state, one rising edge that samples `rst_pin` low clears `prog_state`. It stays 0 while `rst_pin` is then held high.
- R5: In the programming state, each edge with `addr_sel` = 0 loads `addr_port[7:0]` as address bits 7:0. Each edge with `addr_sel` = 1 loads `addr_port[2:0]` as address bits 10:8, and `addr_port[7:3]` has no effect.
- R6: In the programming state with `verify_en` = 1, `data_oe` is 1 and `data_out` shows the stored byte at the latched address.
- R7: In the programming state with `verify_en` = 0, `data_oe` is 0. An edge with `wr_stb` = 1 stores `data_in` at the latched address.
- R8: A location that has never been written reads back as 8'hFF.
- R9: Outside the programming state, `data_oe` stays 0 and `wr_stb` leaves the store unchanged.
- R10: The low address byte keeps its value while `addr_sel` is 1 and the port changes, and the high bits keep their value while `addr_sel` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| osc_clk | input | 1 | Oscillator clock; samples the key and all port inputs |
| rst_n | input | 1 | Asynchronous block reset, active low |
| rst_pin | input | 1 | Reset pin level; carries the serial key, low exits programming |
| addr_sel | input | 1 | 0: port carries address bits 7:0; 1: bits 10:8 on port bits 2:0 |
| verify_en | input | 1 | 1: verify (read out), 0: program (write in) |
| wr_stb | input | 1 | Write strobe in program mode |
| addr_port | input | 8 | Byte-wide multiplexed address port |
| data_in | input | 8 | Byte to be stored in program mode |
| data_out | output | 8 | Stored byte at the latched address while driven |
| data_oe | output | 1 | Output enable for `data_out`; 0 means released |
| prog_state | output | 1 | 1 while the programming state is active |

## Verification
The bound checker watches several rules on every cycle. It checks that the output enable is never raised outside the programming state or in program mode, and that a low reset pin always forces an exit. It checks that entry happens only on an edge that samples the key's last bit, and that each address half is loaded from the port in its own phase and is otherwise held. The bench scenarios cover what needs history across many cycles. They show that a key with one wrong bit does not unlock the device while a full correct key does, that written bytes read back at their addresses, that unwritten locations read all ones, and that a write strobe applied outside the programming state leaves the store unchanged.

// File: rtl/otp_prog_access.sv
module otp_prog_access #(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8,
  parameter int KEY_W  = 10,
  parameter logic [KEY_W-1:0] KEY = 10'h2B6
) (
  input  logic              osc_clk,
  input  logic              rst_n,
  input  logic              rst_pin,
  input  logic              addr_sel,
  input  logic              verify_en,
  input  logic              wr_stb,
  input  logic [DATA_W-1:0] addr_port,
  input  logic [DATA_W-1:0] data_in,
  output logic [DATA_W-1:0] data_out,
  output logic              data_oe,
  output logic              prog_state
);
  localparam int HI_W  = ADDR_W - DATA_W;
  localparam int DEPTH = 1 << ADDR_W;
  localparam int CNT_W = $clog2(KEY_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(KEY_W - 1);

  logic [CNT_W-1:0]  key_pos;
  logic [DATA_W-1:0] addr_lo;
  logic [HI_W-1:0]   addr_hi;
  logic [DATA_W-1:0] store [DEPTH];
  logic              bit_ok;
  logic [ADDR_W-1:0] addr_full;

  assign bit_ok    = (rst_pin == KEY[key_pos]);
  assign addr_full = {addr_hi, addr_lo};

  always_ff @(posedge osc_clk or negedge rst_n) begin
    if (!rst_n) begin
      prog_state <= 1'b0;
      key_pos    <= '0;
    end else if (prog_state) begin
      if (!rst_pin) begin
        prog_state <= 1'b0;
        key_pos    <= '0;
      end
    end else if (!bit_ok) begin
      key_pos <= '0;
    end else if (key_pos == LAST) begin
      prog_state <= 1'b1;
      key_pos    <= '0;
    end else begin
      key_pos <= key_pos + 1'b1;
    end
  end

  always_ff @(posedge osc_clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_lo <= '0;
      addr_hi <= '0;
    end else if (prog_state) begin
      if (addr_sel) addr_hi <= addr_port[HI_W-1:0];
      else          addr_lo <= addr_port;
    end
  end

  always_ff @(posedge osc_clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) store[i] <= '1;
    end else if (prog_state && !verify_en && wr_stb) begin
      store[addr_full] <= data_in;
    end
  end

  assign data_oe  = prog_state && verify_en;
  assign data_out = data_oe ? store[addr_full] : '0;
endmodule

// File: rtl/otp_prog_access_chk.sv
module otp_prog_access_chk #(
  parameter int DATA_W = 8,
  parameter int HI_W   = 3,
  parameter int KEY_W  = 10,
  parameter logic [KEY_W-1:0] KEY = 10'h2B6
) (
  input logic              osc_clk,
  input logic              rst_n,
  input logic              rst_pin,
  input logic              addr_sel,
  input logic              verify_en,
  input logic [DATA_W-1:0] addr_port,
  input logic [DATA_W-1:0] addr_lo,
  input logic [HI_W-1:0]   addr_hi,
  input logic              data_oe,
  input logic              prog_state
);
  AST_OE_NEEDS_PROG: assert property (@(posedge osc_clk) disable iff (!rst_n)
    !prog_state |-> !data_oe); // R9
  AST_NO_OE_IN_PROGRAM: assert property (@(posedge osc_clk) disable iff (!rst_n)
    !verify_en |-> !data_oe); // R7
  AST_EXIT_ON_LOW: assert property (@(posedge osc_clk) disable iff (!rst_n)
    (prog_state && !rst_pin) |=> !prog_state); // R4
  AST_ENTRY_LAST_BIT: assert property (@(posedge osc_clk) disable iff (!rst_n)
    $rose(prog_state) |-> ($past(rst_pin) == KEY[KEY_W-1])); // R2
  AST_LO_CAPTURE: assert property (@(posedge osc_clk) disable iff (!rst_n)
    (prog_state && !addr_sel) |=> (addr_lo == $past(addr_port))); // R5
  AST_HI_CAPTURE: assert property (@(posedge osc_clk) disable iff (!rst_n)
    (prog_state && addr_sel) |=> (addr_hi == $past(addr_port[HI_W-1:0]))); // R5
  AST_LO_HELD: assert property (@(posedge osc_clk) disable iff (!rst_n)
    addr_sel |=> $stable(addr_lo)); // R10
  AST_HI_HELD: assert property (@(posedge osc_clk) disable iff (!rst_n)
    !addr_sel |=> $stable(addr_hi)); // R10
endmodule

bind otp_prog_access otp_prog_access_chk #(
  .DATA_W(DATA_W), .HI_W(HI_W), .KEY_W(KEY_W), .KEY(KEY)
) u_chk (
  .osc_clk(osc_clk), .rst_n(rst_n), .rst_pin(rst_pin), .addr_sel(addr_sel),
  .verify_en(verify_en), .addr_port(addr_port), .addr_lo(addr_lo),
  .addr_hi(addr_hi), .data_oe(data_oe), .prog_state(prog_state)
);

// File: tb/sim_otp_prog_access.sv
module sim_otp_prog_access;
  localparam int CLK_P = 10;
  localparam logic [9:0] KEY = 10'h2B6;
  localparam logic [18:0] VEC [6] = '{
    19'h0005A, 19'h7FF3C, 19'h123A5, 19'h456C3, 19'h0FF01, 19'h10080
  };

  logic osc_clk = 0, rst_n = 0, rst_pin = 1, addr_sel = 0, verify_en = 0, wr_stb = 0;
  logic [7:0] addr_port = 0, data_in = 0, data_out;
  logic data_oe, prog_state;
  int checks = 0, errors = 0;
  bit done = 0;

  always #(CLK_P/2) osc_clk = ~osc_clk;

  otp_prog_access u0 (
    .osc_clk(osc_clk), .rst_n(rst_n), .rst_pin(rst_pin), .addr_sel(addr_sel),
    .verify_en(verify_en), .wr_stb(wr_stb), .addr_port(addr_port), .data_in(data_in),
    .data_out(data_out), .data_oe(data_oe), .prog_state(prog_state)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic send_key(input logic [9:0] k);
    repeat (5) begin @(negedge osc_clk); rst_pin = 1; end
    for (int i = 0; i < 10; i++) begin
      @(negedge osc_clk); rst_pin = k[i];
    end
    @(negedge osc_clk); rst_pin = 1;
    #1;
  endtask

  task automatic set_addr(input logic [10:0] a);
    @(negedge osc_clk); addr_sel = 0; addr_port = a[7:0];
    @(negedge osc_clk); addr_sel = 1; addr_port = {5'b10101, a[10:8]};
    @(negedge osc_clk); addr_port = 8'h00;
  endtask

  task automatic wr(input logic [10:0] a, input logic [7:0] d);
    set_addr(a);
    verify_en = 0; data_in = d; wr_stb = 1;
    #1 chk(data_oe == 0, "R7", data_oe, 0);
    @(negedge osc_clk); wr_stb = 0;
  endtask

  task automatic rd(input logic [10:0] a, input logic [7:0] e, input string req);
    set_addr(a);
    verify_en = 1;
    #1 chk(data_oe == 1 && data_out == e, req, data_out, e);
    verify_en = 0;
  endtask

  initial begin
    repeat (100000) @(posedge osc_clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge osc_clk);
    verify_en = 1;
    #1 chk(prog_state == 0 && data_oe == 0, "R1 in reset", {prog_state, data_oe}, 0);
    rst_n = 1;
    @(negedge osc_clk);
    chk(prog_state == 0 && data_oe == 0, "R1 after release", {prog_state, data_oe}, 0);
    verify_en = 0;

    send_key(KEY ^ 10'h010);
    chk(prog_state == 0, "R3 bad key", prog_state, 0);
    send_key(KEY);
    chk(prog_state == 1, "R2 key entry", prog_state, 1);
    chk(prog_state == 1, "R3 entry after bad key", prog_state, 1);

    foreach (VEC[i]) wr(VEC[i][18:8], VEC[i][7:0]);
    foreach (VEC[i]) rd(VEC[i][18:8], VEC[i][7:0], "R6 R5 R10 readback");

    rd(11'h555, 8'hFF, "R8 blank");
    rd(11'h7FE, 8'hFF, "R8 blank");
    rd(11'h100, 8'h80, "R5 high bits");

    @(negedge osc_clk); rst_pin = 0;
    @(negedge osc_clk); rst_pin = 1;
    chk(prog_state == 0, "R4 exit", prog_state, 1'b0);
    repeat (3) @(negedge osc_clk);
    chk(prog_state == 0, "R4 stays out", prog_state, 1'b0);

    addr_sel = 0; addr_port = 8'h00; verify_en = 0; data_in = 8'h11; wr_stb = 1;
    repeat (3) @(negedge osc_clk);
    wr_stb = 0; verify_en = 1;
    #1 chk(data_oe == 0, "R9 no drive outside", data_oe, 0);
    verify_en = 0;

    send_key(KEY);
    chk(prog_state == 1, "R2 reentry", prog_state, 1);
    rd(11'h100, 8'h80, "R9 store untouched");
    rd(11'h000, 8'h5A, "R9 store untouched");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule